// File: doc/BRIEF.md
# Radix Page Tree Walker

This block turns an effective address into a real address by walking a multi-level radix page tree held in memory. A pulse on `start` loads the effective address, the base of the root table, the root index size and the starting address-space size. The walker then fetches one 64-bit tree entry per level over a read request/response port. At each level it takes an index field out of the effective address, reads that slot of the current table, and either goes down to a lower-level table or stops at a leaf. The geometry of each level is checked before its read is issued.

When the walk ends, `done` pulses for one cycle. On success the block reports the real address, the page-size exponent, the raw leaf entry and the address it was read from. On failure `fault` is set and `cause` says why: either the entry had no valid bit, or the tree shape was illegal at that depth. A table base with stray low bits is not a fault. The walker clears those bits and uses the aligned base.

Both memory channels use valid/ready handshakes. A request sits on `mrq_valid`/`mrq_addr` and does not change until `mrq_ready` is seen high at a clock edge. The response is accepted on the edge where `mrs_valid` and `mrs_ready` are both high. `mrs_ready` is high only while a read is outstanding. The memory side may stall either channel for any number of cycles, and the walk waits for it.

Top module: `rtree_walker`

## Requirements
- R1: The entry read at each level is at aligned base + 8 × index. The index is `ea` shifted right by (remaining size − index size) and masked to index-size bits. Every request address is therefore a multiple of 8.
- R2: Before use, a table base (root or from an entry) has its low (index size + 3) bits cleared. A misaligned base never causes a fault.
- R3: Depth 0 is legal only with remaining size 52 and index size 13. Depths 1 and 2 need index size 9. Depth 3 accepts 9 or 5. Depth 4 and deeper is illegal. An illegal level ends the walk with `cause` = 2'b10 and issues no read for that level, so a walk makes at most 4 reads.
- R4: A fetched entry with bit 63 (valid) clear ends the walk with `fault` = 1 and `cause` = 2'b01.
- R5: After each valid entry, the remaining size drops by the current index size. On a leaf, `page_bits` reports the remaining size, which is one of 39, 30, 21, 16 or 12.
- R6: An entry with bit 62 (leaf) clear is a directory entry. Bits 4:0 give the next index size, bits 55:8 give the next table base (its bits 7:0 are zero), and the walk continues.
- R7: On a leaf, `raddr` takes the page frame from entry bits 55:12 with its low `page_bits` bits replaced by the same bits of `ea`. `leaf_pte` holds the raw entry and `leaf_addr` holds its address.
- R8: At most one read is outstanding. A request held back by `mrq_ready` low keeps `mrq_valid` and `mrq_addr` stable. `mrs_ready` is high only while a read is outstanding.
- R9: `start` is acted on only while `busy` is low. A pulse during a walk changes neither its reads nor its result and produces no extra `done`.
- R10: After reset: `busy`, `mrq_valid`, `mrs_ready` and `done` are all low.
- R11: `done` is a single-cycle pulse with `busy` low. On success `fault` is 0 and `cause` is 0. On a fault exactly one cause bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken while idle) |
| ea | input | 64 | Effective address to translate |
| root_base | input | 56 | Root table base address |
| root_nls | input | 5 | Root index size in bits |
| root_size | input | 6 | Starting address-space size in bits |
| busy | output | 1 | A walk is in progress |
| mrq_valid | output | 1 | Read request valid |
| mrq_ready | input | 1 | Read request accepted |
| mrq_addr | output | 56 | Read request byte address |
| mrs_valid | input | 1 | Read response valid |
| mrs_ready | output | 1 | Walker can take the response |
| mrs_data | input | 64 | Read response entry |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk failed |
| cause | output | 2 | bit0 no valid entry, bit1 illegal geometry |
| raddr | output | 56 | Translated real address |
| page_bits | output | 6 | Page-size exponent of the leaf |
| leaf_pte | output | 64 | Raw leaf entry |
| leaf_addr | output | 56 | Address the leaf was read from |

## Verification
Some properties are checked by assertions on every cycle:
- the single-outstanding-read rule and request stability under back-pressure;
- 8-byte alignment of every request;
- the four-read depth limit;
- the one-hot form of `cause` at completion;
- that a walk only begins after `start`;
- that a successful leaf size is one of the legal exponents.

Other properties need the bench's scenarios, because only they know what the tree in memory contains:
- whether the right slot of the right table was read;
- that a misaligned base was silently rounded down;
- which geometry error or missing entry stopped the walk;
- that the real address merges frame and offset at the correct bit.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
  localparam int ENT_W     = 64;
  localparam int ENT_VALID = 63;
  localparam int ENT_LEAF  = 62;
  localparam int BASE_LSB  = 8;
  localparam int CAUSE_W   = 2;
  localparam logic [CAUSE_W-1:0] CAUSE_NOENT  = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_BADGEO = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT
  } walk_state_e;

  function automatic logic [63:0] low_mask(input int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction
endpackage

// File: rtl/rtw_geom_check.sv
module rtw_geom_check #(
  parameter int SZ_W      = 6,
  parameter int NLS_W     = 5,
  parameter int LVL_W     = 3,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13,
  parameter int MID_NLS   = 9,
  parameter int ALT_NLS   = 5,
  parameter int LAST_LVL  = 3
) (
  input  logic [LVL_W-1:0] level,
  input  logic [SZ_W-1:0]  size,
  input  logic [NLS_W-1:0] nls,
  output logic             legal
);
  always_comb begin
    if (level == '0)
      legal = (size == SZ_W'(ROOT_SIZE)) && (nls == NLS_W'(ROOT_NLS));
    else if (level < LVL_W'(LAST_LVL))
      legal = (nls == NLS_W'(MID_NLS));
    else if (level == LVL_W'(LAST_LVL))
      legal = (nls == NLS_W'(MID_NLS)) || (nls == NLS_W'(ALT_NLS));
    else
      legal = 1'b0;
  end
endmodule

// File: rtl/rtw_index_gen.sv
module rtw_index_gen #(
  parameter int EA_W         = 64,
  parameter int PA_W         = 56,
  parameter int SZ_W         = 6,
  parameter int NLS_W        = 5,
  parameter int ENT_BYTES_LG = 3
) (
  input  logic [EA_W-1:0]  ea,
  input  logic [PA_W-1:0]  base,
  input  logic [SZ_W-1:0]  size,
  input  logic [NLS_W-1:0] nls,
  output logic [PA_W-1:0]  entry_addr
);
  logic [SZ_W-1:0] shamt;
  logic [EA_W-1:0] idx;
  logic [EA_W-1:0] amask;
  logic [EA_W-1:0] sum;
  logic            unused_hi;

  always_comb begin
    shamt      = size - SZ_W'(nls);
    idx        = (ea >> shamt) & EA_W'(rtw_pkg::low_mask(int'(nls)));
    amask      = EA_W'(rtw_pkg::low_mask(int'(nls) + ENT_BYTES_LG));
    sum        = (EA_W'(base) & ~amask) + (idx << ENT_BYTES_LG);
    entry_addr = sum[PA_W-1:0];
  end

  assign unused_hi = ^sum[EA_W-1:PA_W];
endmodule

// File: rtl/rtw_pte_decode.sv
module rtw_pte_decode
  import rtw_pkg::*;
#(
  parameter int EA_W  = 64,
  parameter int PA_W  = 56,
  parameter int SZ_W  = 6,
  parameter int NLS_W = 5,
  parameter int PG_LG = 12
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [EA_W-1:0]  ea,
  input  logic [SZ_W-1:0]  size_left,
  output logic             ent_valid,
  output logic             ent_leaf,
  output logic [NLS_W-1:0] next_nls,
  output logic [PA_W-1:0]  next_base,
  output logic [PA_W-1:0]  real_addr
);
  logic [EA_W-1:0] frame;
  logic [EA_W-1:0] pmask;
  logic [EA_W-1:0] merged;
  logic            unused_bits;

  always_comb begin
    ent_valid = entry[ENT_VALID];
    ent_leaf  = entry[ENT_LEAF];
    next_nls  = entry[NLS_W-1:0];
    next_base = {entry[PA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    frame     = EA_W'({entry[PA_W-1:PG_LG], {PG_LG{1'b0}}});
    pmask     = EA_W'(low_mask(int'(size_left)));
    merged    = (frame & ~pmask) | (ea & pmask);
    real_addr = merged[PA_W-1:0];
  end

  assign unused_bits = ^{entry[ENT_LEAF-1:PA_W], entry[BASE_LSB-1:NLS_W], merged[EA_W-1:PA_W]};
endmodule

// File: rtl/rtree_walker.sv
module rtree_walker
  import rtw_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int PA_W      = 56,
  parameter int SZ_W      = 6,
  parameter int NLS_W     = 5,
  parameter int PG_LG     = 12,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13,
  parameter int MID_NLS   = 9,
  parameter int ALT_NLS   = 5,
  parameter int LAST_LVL  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [EA_W-1:0]    ea,
  input  logic [PA_W-1:0]    root_base,
  input  logic [NLS_W-1:0]   root_nls,
  input  logic [SZ_W-1:0]    root_size,
  output logic               busy,
  output logic               mrq_valid,
  input  logic               mrq_ready,
  output logic [PA_W-1:0]    mrq_addr,
  input  logic               mrs_valid,
  output logic               mrs_ready,
  input  logic [ENT_W-1:0]   mrs_data,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic [PA_W-1:0]    raddr,
  output logic [SZ_W-1:0]    page_bits,
  output logic [ENT_W-1:0]   leaf_pte,
  output logic [PA_W-1:0]    leaf_addr
);
  localparam int LVL_W = $clog2(LAST_LVL + 2);

  walk_state_e      state_q;
  logic [EA_W-1:0]  ea_q;
  logic [PA_W-1:0]  base_q;
  logic [NLS_W-1:0] nls_q;
  logic [SZ_W-1:0]  size_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  addr_q;

  logic             geo_ok;
  logic [PA_W-1:0]  slot_addr;
  logic [SZ_W-1:0]  size_after;
  logic             e_valid;
  logic             e_leaf;
  logic [NLS_W-1:0] e_nls;
  logic [PA_W-1:0]  e_base;
  logic [PA_W-1:0]  e_real;

  assign size_after = size_q - SZ_W'(nls_q);

  rtw_geom_check #(
    .SZ_W(SZ_W), .NLS_W(NLS_W), .LVL_W(LVL_W),
    .ROOT_SIZE(ROOT_SIZE), .ROOT_NLS(ROOT_NLS),
    .MID_NLS(MID_NLS), .ALT_NLS(ALT_NLS), .LAST_LVL(LAST_LVL)
  ) u_geom (
    .level(lvl_q), .size(size_q), .nls(nls_q), .legal(geo_ok)
  );

  rtw_index_gen #(
    .EA_W(EA_W), .PA_W(PA_W), .SZ_W(SZ_W), .NLS_W(NLS_W), .ENT_BYTES_LG(3)
  ) u_index (
    .ea(ea_q), .base(base_q), .size(size_q), .nls(nls_q), .entry_addr(slot_addr)
  );

  rtw_pte_decode #(
    .EA_W(EA_W), .PA_W(PA_W), .SZ_W(SZ_W), .NLS_W(NLS_W), .PG_LG(PG_LG)
  ) u_decode (
    .entry(mrs_data), .ea(ea_q), .size_left(size_after),
    .ent_valid(e_valid), .ent_leaf(e_leaf), .next_nls(e_nls),
    .next_base(e_base), .real_addr(e_real)
  );

  assign busy      = (state_q != ST_IDLE);
  assign mrq_valid = (state_q == ST_REQ);
  assign mrq_addr  = addr_q;
  assign mrs_ready = (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ea_q      <= '0;
      base_q    <= '0;
      nls_q     <= '0;
      size_q    <= '0;
      lvl_q     <= '0;
      addr_q    <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      cause     <= '0;
      raddr     <= '0;
      page_bits <= '0;
      leaf_pte  <= '0;
      leaf_addr <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ea_q    <= ea;
            base_q  <= root_base;
            nls_q   <= root_nls;
            size_q  <= root_size;
            lvl_q   <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!geo_ok) begin
            done    <= 1'b1;
            fault   <= 1'b1;
            cause   <= CAUSE_BADGEO;
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= slot_addr;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mrq_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mrs_valid) begin
            if (!e_valid) begin
              done    <= 1'b1;
              fault   <= 1'b1;
              cause   <= CAUSE_NOENT;
              state_q <= ST_IDLE;
            end else if (e_leaf) begin
              size_q    <= size_after;
              done      <= 1'b1;
              fault     <= 1'b0;
              cause     <= '0;
              raddr     <= e_real;
              page_bits <= size_after;
              leaf_pte  <= mrs_data;
              leaf_addr <= addr_q;
              state_q   <= ST_IDLE;
            end else begin
              size_q  <= size_after;
              nls_q   <= e_nls;
              base_q  <= e_base;
              lvl_q   <= lvl_q + LVL_W'(1);
              state_q <= ST_CHECK;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtree_walker_chk.sv
module rtree_walker_chk #(
  parameter int PA_W      = 56,
  parameter int SZ_W      = 6,
  parameter int CAUSE_W   = 2,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13,
  parameter int MID_NLS   = 9,
  parameter int ALT_NLS   = 5,
  parameter int LAST_LVL  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               mrq_valid,
  input logic               mrq_ready,
  input logic [PA_W-1:0]    mrq_addr,
  input logic               mrs_valid,
  input logic               mrs_ready,
  input logic               done,
  input logic               fault,
  input logic [CAUSE_W-1:0] cause,
  input logic [SZ_W-1:0]    page_bits
);
  localparam int CNT_W = $clog2(LAST_LVL + 3);
  localparam int PS0   = ROOT_SIZE - ROOT_NLS;
  localparam int PS1   = PS0 - MID_NLS;
  localparam int PS2   = PS1 - MID_NLS;
  localparam int PS3A  = PS2 - MID_NLS;
  localparam int PS3B  = PS2 - ALT_NLS;

  logic             pending;
  logic [CNT_W-1:0] reads;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      reads   <= '0;
    end else begin
      if (mrq_valid && mrq_ready) pending <= 1'b1;
      else if (mrs_valid && mrs_ready) pending <= 1'b0;
      if (start && !busy) reads <= '0;
      else if (mrq_valid && mrq_ready) reads <= reads + CNT_W'(1);
    end
  end

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mrq_valid |-> !pending); // R8
  AST_RSP_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_ready |-> pending); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrq_valid && !mrq_ready) |=> (mrq_valid && $stable(mrq_addr))); // R8
  AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mrq_valid |-> (mrq_addr[2:0] == 3'b000)); // R1
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    reads <= CNT_W'(LAST_LVL + 1)); // R3
  AST_CAUSE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault ? ($countones(cause) == 1) : (cause == '0))); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R9
  AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (page_bits == SZ_W'(PS0) || page_bits == SZ_W'(PS1) ||
                          page_bits == SZ_W'(PS2) || page_bits == SZ_W'(PS3A) ||
                          page_bits == SZ_W'(PS3B))); // R5
endmodule

bind rtree_walker rtree_walker_chk #(
  .PA_W(PA_W), .SZ_W(SZ_W), .CAUSE_W(rtw_pkg::CAUSE_W),
  .ROOT_SIZE(ROOT_SIZE), .ROOT_NLS(ROOT_NLS), .MID_NLS(MID_NLS),
  .ALT_NLS(ALT_NLS), .LAST_LVL(LAST_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .mrq_valid(mrq_valid), .mrq_ready(mrq_ready), .mrq_addr(mrq_addr),
  .mrs_valid(mrs_valid), .mrs_ready(mrs_ready), .done(done),
  .fault(fault), .cause(cause), .page_bits(page_bits)
);

// File: tb/rtree_walker_bench.sv
`timescale 1ns/1ps
module rtree_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ea = '0;
  logic [55:0] root_base = '0;
  logic [4:0]  root_nls = '0;
  logic [5:0]  root_size = '0;
  logic        busy, mrq_valid, mrs_ready, done, fault;
  logic        mrq_ready = 1'b0;
  logic        mrs_valid = 1'b0;
  logic [55:0] mrq_addr, raddr, leaf_addr;
  logic [63:0] mrs_data = '0;
  logic [63:0] leaf_pte;
  logic [1:0]  cause;
  logic [5:0]  page_bits;

  always #5 clk = ~clk;

  rtree_walker u_rtree_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .root_base(root_base),
    .root_nls(root_nls), .root_size(root_size), .busy(busy),
    .mrq_valid(mrq_valid), .mrq_ready(mrq_ready), .mrq_addr(mrq_addr),
    .mrs_valid(mrs_valid), .mrs_ready(mrs_ready), .mrs_data(mrs_data),
    .done(done), .fault(fault), .cause(cause), .raddr(raddr),
    .page_bits(page_bits), .leaf_pte(leaf_pte), .leaf_addr(leaf_addr)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [63:0] mem [longint unsigned];
  logic [55:0] reqlog [0:7];
  int          nreads = 0;
  bit          stall_mode = 0;

  localparam logic [55:0] ROOT = 56'h10_0000;

  function automatic logic [63:0] mem_rd(input logic [55:0] a);
    longint unsigned k = longint'(64'(a));
    if (mem.exists(k)) return mem[k];
    return 64'd0;
  endfunction

  function automatic void put(input logic [55:0] a, input logic [63:0] v);
    mem[longint'(64'(a))] = v;
  endfunction

  function automatic logic [63:0] mk_dir(input logic [55:0] b, input logic [4:0] n);
    return 64'h8000_0000_0000_0000 | {8'h00, b[55:8], 8'h00} | {59'd0, n};
  endfunction

  function automatic logic [63:0] mk_leaf(input logic [55:0] frame);
    return 64'hC000_0000_0000_0000 | {8'h00, frame[55:12], 12'h000} | 64'h1A5;
  endfunction

  function automatic logic [63:0] mk_ea(input int i0, input int i1, input int i2,
                                        input int i3, input int off);
    return (64'(i0) << 39) | (64'(i1) << 30) | (64'(i2) << 21) | (64'(i3) << 12) | 64'(off);
  endfunction

  // Reference walk computed from the requirements
  logic [55:0] x_raddr, x_leaf_addr;
  logic [5:0]  x_pb;
  logic [63:0] x_pte;
  logic [1:0]  x_cause;
  int          x_reads;
  logic [55:0] x_log [0:7];

  task automatic ref_walk(input logic [63:0] e_a, input logic [55:0] b0,
                          input logic [4:0] n0, input logic [5:0] s0);
    int lvl = 0;
    logic [5:0] sz = s0;
    logic [4:0] n = n0;
    logic [55:0] b = b0;
    logic [63:0] ent, idx;
    logic [55:0] a, pm;
    bit legal, fin;
    x_reads = 0; x_cause = 2'b00; fin = 0;
    while (!fin) begin
      if (lvl == 0) legal = (sz == 6'd52) && (n == 5'd13);
      else if (lvl <= 2) legal = (n == 5'd9);
      else if (lvl == 3) legal = (n == 5'd9) || (n == 5'd5);
      else legal = 0;
      if (!legal) begin x_cause = 2'b10; fin = 1; end
      else begin
        idx = (e_a >> (sz - 6'(n))) & ((64'd1 << n) - 64'd1);
        a = (b & ~((56'd1 << (n + 5'd3)) - 56'd1)) + 56'(idx * 8);
        x_log[x_reads] = a;
        x_reads++;
        ent = mem_rd(a);
        if (!ent[63]) begin x_cause = 2'b01; fin = 1; end
        else begin
          sz = sz - 6'(n);
          if (ent[62]) begin
            pm = (56'd1 << sz) - 56'd1;
            x_raddr = ({ent[55:12], 12'h000} & ~pm) | (e_a[55:0] & pm);
            x_pb = sz; x_pte = ent; x_leaf_addr = a; fin = 1;
          end else begin
            n = ent[4:0]; b = {ent[55:8], 8'h00}; lvl++;
          end
        end
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model: decides handshakes half a cycle ahead of each edge
  initial begin
    int cyc = 0;
    int dly = 0;
    bit pend = 0, req_hs = 0, rsp_hs = 0;
    logic [55:0] pend_addr = '0, hs_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        mrq_ready = 0; mrs_valid = 0; pend = 0; req_hs = 0; rsp_hs = 0;
      end else begin
        if (req_hs) begin
          pend = 1; pend_addr = hs_addr; dly = stall_mode ? 3 : 0;
          if (nreads < 8) reqlog[nreads] = hs_addr;
          nreads++;
        end
        if (rsp_hs) begin mrs_valid = 0; pend = 0; end
        mrq_ready = stall_mode ? cyc[0] : 1'b1;
        if (pend && !mrs_valid) begin
          if (dly == 0) begin mrs_valid = 1; mrs_data = mem_rd(pend_addr); end
          else dly--;
        end
        #1;
        req_hs = mrq_valid && mrq_ready;
        hs_addr = mrq_addr;
        rsp_hs = mrs_valid && mrs_ready;
      end
    end
  end

  task automatic pulse_start(input logic [63:0] e_a, input logic [55:0] b,
                             input logic [4:0] n, input logic [5:0] s);
    @(negedge clk);
    ea = e_a; root_base = b; root_nls = n; root_size = s; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    seen = done;
  endtask

  task automatic walk(input logic [63:0] e_a, input logic [55:0] b,
                      input logic [4:0] n, input logic [5:0] s, input string req);
    bit seen;
    ref_walk(e_a, b, n, s);
    nreads = 0;
    pulse_start(e_a, b, n, s);
    wait_done(seen);
    chk(seen, "R11", "done seen", 64'(seen), 64'd1);
    chk(fault == (x_cause != 2'b00), req, "fault", 64'(fault), 64'(x_cause != 2'b00));
    chk(cause == x_cause, req, "cause", 64'(cause), 64'(x_cause));
    chk(nreads == x_reads, "R3", "read count", 64'(nreads), 64'(x_reads));
    for (int k = 0; k < x_reads && k < 8; k++)
      chk(reqlog[k] == x_log[k], "R1", "slot address", 64'(reqlog[k]), 64'(x_log[k]));
    if (x_cause == 2'b00) begin
      chk(raddr == x_raddr, "R7", "raddr", 64'(raddr), 64'(x_raddr));
      chk(page_bits == x_pb, "R5", "page_bits", 64'(page_bits), 64'(x_pb));
      chk(leaf_pte == x_pte, "R7", "leaf_pte", leaf_pte, x_pte);
      chk(leaf_addr == x_leaf_addr, "R7", "leaf_addr", 64'(leaf_addr), 64'(x_leaf_addr));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    int extra;
    // Tree construction
    put(ROOT + 56'(3*8), mk_dir(56'h20_0000, 5'd9));
    put(56'h20_0000 + 56'(5*8), mk_dir(56'h30_0000, 5'd9));
    put(56'h30_0000 + 56'(7*8), mk_dir(56'h40_0000, 5'd9));
    for (int i = 0; i < 512; i++)
      if (i % 37 != 0) put(56'h40_0000 + 56'(i*8), mk_leaf(56'h8000_0000 + 56'(i << 12)));
    put(ROOT + 56'(9*8), mk_leaf(56'h00A5_1234_5678_9000));
    put(56'h20_0000 + 56'(6*8), mk_leaf(56'h0077_4444_5000));
    put(56'h30_0000 + 56'(8*8), mk_leaf(56'h0066_1111_3000));
    put(56'h30_0000 + 56'(9*8), mk_dir(56'h50_0000, 5'd5));
    for (int j = 0; j < 32; j++) put(56'h50_0000 + 56'(j*8), mk_leaf(56'h9000_0000 + 56'(j << 16)));
    put(56'h30_0000 + 56'(10*8), mk_dir(56'h60_0100, 5'd9));
    put(56'h60_0000 + 56'(4*8), mk_leaf(56'h7700_0000));
    put(ROOT + 56'(4*8), mk_dir(56'h70_0000, 5'd7));
    put(56'h30_0000 + 56'(11*8), mk_dir(56'h71_0000, 5'd9));
    put(56'h71_0000 + 56'(2*8), mk_dir(56'h72_0000, 5'd9));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!busy, "R10", "busy after reset", 64'(busy), 64'd0);
    chk(!mrq_valid, "R10", "mrq_valid after reset", 64'(mrq_valid), 64'd0);
    chk(!mrs_ready, "R10", "mrs_ready after reset", 64'(mrs_ready), 64'd0);
    chk(!done, "R10", "done after reset", 64'(done), 64'd0);

    // Full sweep of the four-level region (R1 R5 R6 R7, R4 on holes)
    for (int i = 0; i < 512; i++)
      walk(mk_ea(3, 5, 7, i, (i * 7) & 12'hFFF), ROOT, 5'd13, 6'd52, (i % 37 == 0) ? "R4" : "R6");
    // direct arithmetic check on one 4 KiB leaf
    walk(mk_ea(3, 5, 7, 100, 12'h3C8), ROOT, 5'd13, 6'd52, "R7");
    chk(raddr == 56'h8000_0000 + 56'(100 << 12) + 56'h3C8, "R7", "4K raddr",
        64'(raddr), 64'(56'h8000_0000 + 56'(100 << 12) + 56'h3C8));
    chk(page_bits == 6'd12, "R5", "4K page_bits", 64'(page_bits), 64'd12);

    // Leaves at shallower depths
    walk(mk_ea(9, 17, 33, 44, 12'h321) | 64'hFFF0_0000_0000_0000, ROOT, 5'd13, 6'd52, "R7");
    chk(page_bits == 6'd39, "R5", "level0 leaf size", 64'(page_bits), 64'd39);
    walk(mk_ea(3, 6, 400, 12, 12'h0AB), ROOT, 5'd13, 6'd52, "R7");
    chk(page_bits == 6'd30, "R5", "level1 leaf size", 64'(page_bits), 64'd30);
    walk(mk_ea(3, 5, 8, 301, 12'hFFF), ROOT, 5'd13, 6'd52, "R7");
    chk(page_bits == 6'd21, "R5", "level2 leaf size", 64'(page_bits), 64'd21);

    // Five-bit last level sweep
    for (int j = 0; j < 32; j++)
      walk(mk_ea(3, 5, 9, 0, 0) | (64'(j) << 16) | 64'((j * 1237) & 16'hFFFF), ROOT, 5'd13, 6'd52, "R3");
    chk(page_bits == 6'd16, "R5", "nls5 leaf size", 64'(page_bits), 64'd16);

    // Misaligned directory base forced aligned
    walk(mk_ea(3, 5, 10, 4, 12'h010), ROOT, 5'd13, 6'd52, "R2");
    chk(reqlog[3] == 56'h60_0020, "R2", "aligned slot", 64'(reqlog[3]), 64'h60_0020);
    chk(!fault, "R2", "no fault on misaligned base", 64'(fault), 64'd0);
    // Misaligned root base
    walk(mk_ea(3, 5, 7, 1, 12'h004), ROOT | 56'h00_8008, 5'd13, 6'd52, "R2");
    chk(reqlog[0] == ROOT + 56'd24, "R2", "aligned root slot", 64'(reqlog[0]), 64'(ROOT + 56'd24));

    // Geometry faults
    walk(mk_ea(4, 1, 1, 1, 0), ROOT, 5'd13, 6'd52, "R3");
    chk(cause == 2'b10 && nreads == 1, "R3", "bad nls at depth1", 64'({cause, 8'(nreads)}), 64'h201);
    walk(mk_ea(3, 5, 11, 2, 0), ROOT, 5'd13, 6'd52, "R3");
    chk(cause == 2'b10 && nreads == 4, "R3", "depth4 illegal", 64'({cause, 8'(nreads)}), 64'h204);
    walk(mk_ea(3, 5, 7, 1, 0), ROOT, 5'd13, 6'd48, "R3");
    chk(cause == 2'b10 && nreads == 0, "R3", "bad root size", 64'({cause, 8'(nreads)}), 64'h200);
    walk(mk_ea(3, 5, 7, 1, 0), ROOT, 5'd12, 6'd52, "R3");
    chk(nreads == 0, "R3", "bad root nls no read", 64'(nreads), 64'd0);
    // Missing entry at root
    walk(mk_ea(100, 0, 0, 0, 0), ROOT, 5'd13, 6'd52, "R4");
    chk(cause == 2'b01, "R4", "missing root entry", 64'(cause), 64'd1);

    // Back-pressure on both channels (R8)
    stall_mode = 1;
    for (int i = 1; i < 40; i++)
      walk(mk_ea(3, 5, 7, i * 13, i), ROOT, 5'd13, 6'd52, "R8");
    stall_mode = 0;

    // Start during a walk is ignored (R9)
    ref_walk(mk_ea(3, 5, 7, 200, 12'h055), ROOT, 5'd13, 6'd52);
    nreads = 0;
    pulse_start(mk_ea(3, 5, 7, 200, 12'h055), ROOT, 5'd13, 6'd52);
    @(negedge clk);
    ea = mk_ea(9, 0, 0, 0, 0); start = 1;
    @(negedge clk);
    start = 0;
    wait_done(seen);
    chk(raddr == x_raddr, "R9", "result unchanged", 64'(raddr), 64'(x_raddr));
    chk(nreads == x_reads, "R9", "reads unchanged", 64'(nreads), 64'(x_reads));
    @(negedge clk);
    chk(!done, "R11", "done single cycle", 64'(done), 64'd0);
    extra = 0;
    for (int t = 0; t < 30; t++) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, "R9", "no extra done", 64'(extra), 64'd0);
    chk(!busy, "R9", "idle after ignored start", 64'(busy), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule